// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block gives a host CPU two 8-bit registers for the handshake lines of a modem processor. The control register drives the DTR and RTS outputs and two general-purpose outputs. It also enables the output driver of the interrupt pin and switches a local loopback mode. In loopback, the four control outputs stand in for the four handshake inputs. A loopback flag is also brought out so that the serial datapath can return transmitted data to its receiver.

The status register shows the current levels of CTS, DSR, RI and DCD. It also holds four change flags. Each flag records an event on its line since the status register was last read, and reading the status register clears all four. Before any change detection, the handshake inputs pass through a synchronizer whose depth is a parameter. The interrupt request comes only from the ring and carrier change flags.

Register access uses one select bit: `reg_sel` = 0 addresses the control register and `reg_sel` = 1 addresses the status register. Read data is combinational from the registers. A read takes effect (clears the flags) on the clock edge where `rd_en` is high.

Top module: `modem_ctl_regs`

## Requirements
- R1: After reset the control register reads 0x00, every control output is 0, the interrupt request is 0 and the interrupt pin driver is disabled.
- R2: A write to the control register stores bits 4..0. Bits 7..5 always read back as 0. Bit 0 drives DTR, bit 1 drives RTS, bit 2 drives general output 1, bit 3 drives general output 2, and bit 4 is the loopback flag.
- R3: A write with `reg_sel` = 1 changes neither register.
- R4: Status bit 4 shows CTS, bit 5 shows DSR, bit 6 shows the inverse of RI and bit 7 shows DCD. Each bit follows its input SYNC_STAGES+1 clock edges after the input changes.
- R5: Status bits 0, 1 and 3 set to 1 when CTS, DSR or DCD, respectively, changes level in either direction.
- R6: Status bit 2 sets only when RI falls from 1 to 0. A rising RI leaves it unchanged.
- R7: A read of the status register clears bits 3..0 and returns the values they held before the clear. A read of the control register clears nothing.
- R8: When a change occurs on the same edge as a clearing status read, the corresponding flag stays set.
- R9: The interrupt request is 1 exactly when status bit 2 or bit 3 is set. Bits 0 and 1 do not raise it.
- R10: The interrupt pin driver enable equals control bit 3.
- R11: In loopback the external inputs are ignored. CTS takes RTS, DSR takes DTR, RI takes general output 1 and DCD takes general output 2.
- R12: Input levels present when reset is released produce no change flags.
- R13: Entering or leaving loopback that alters an effective line level sets that line's change flag under R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status flags when reg_sel = 1) |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| ri_i | input | 1 | Ring indicator input, asynchronous |
| dcd_i | input | 1 | Carrier detect input, asynchronous |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| gp1_o | output | 1 | General-purpose output 1 |
| gp2_o | output | 1 | General-purpose output 2 |
| loop_o | output | 1 | Loopback active, for the serial datapath |
| irq_o | output | 1 | Modem status interrupt request |
| irq_oe_o | output | 1 | Output enable of the interrupt pin driver |

## Verification
The bench builds the block with the default two-stage synchronizer. With that depth the arming window is three cycles, so a level held across reset release can be checked for the absence of a flag (R12). That depth also makes it possible to line up an input change with a clearing read on exactly the edge where both act, which checks R8. A vector table steps the block through sequences that move in and out of loopback. It includes steps where a control write and an input change arrive together and the effective RI level passes through an intermediate value, so the falling-edge rule is checked on that path as well.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  // control register bit positions (decoded by the output pins)
  localparam int B_DTR  = 0;
  localparam int B_RTS  = 1;
  localparam int B_GP1  = 2;
  localparam int B_GP2  = 3;
  localparam int B_LOOP = 4;

  // handshake line index; also the position of each change flag in status
  localparam int L_CTS  = 0;
  localparam int L_DSR  = 1;
  localparam int L_RI   = 2;
  localparam int L_DCD  = 3;
  localparam int NLINES = 4;

  localparam logic [7:0] CTL_MASK = 8'h1F;

  typedef logic [NLINES-1:0] lines_t;

  // line levels produced by the control outputs in loopback
  function automatic lines_t loop_lines(input logic [7:0] ctl);
    lines_t l;
    l[L_CTS] = ctl[B_RTS];
    l[L_DSR] = ctl[B_DTR];
    l[L_RI]  = ctl[B_GP1];
    l[L_DCD] = ctl[B_GP2];
    return l;
  endfunction

  // events between two samples: any toggle, except RI which is trailing-edge only
  function automatic lines_t line_events(input lines_t prev, input lines_t cur);
    lines_t e;
    e        = prev ^ cur;
    e[L_RI]  = prev[L_RI] & ~cur[L_RI];
    return e;
  endfunction

  // status word: live levels on top, change flags below
  function automatic logic [7:0] status_word(input lines_t dlt, input lines_t lvl);
    return {lvl[L_DCD], ~lvl[L_RI], lvl[L_DSR], lvl[L_CTS], dlt};
  endfunction

  // next flag state: clear on read, events win over the clear
  function automatic lines_t next_flags(input lines_t cur, input logic clr, input lines_t evt);
    return (clr ? '0 : cur) | evt;
  endfunction

endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mcr_ctl_reg.sv
module mcr_ctl_reg
  import mcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl <= 8'h00;
    else if (we) ctl <= wdata & CTL_MASK;
  end
endmodule

// File: rtl/mcr_delta.sv
module mcr_delta
  import mcr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  lines_t lvl,
  output lines_t ref_lvl,
  output lines_t evt,
  output lines_t dlt,
  output logic   armed
);
  // the reference must have seen the first synchronized sample before events count
  localparam int ARM_CNT = STAGES + 1;
  localparam int CNT_W   = $clog2(ARM_CNT + 1);

  logic [CNT_W-1:0] cnt;

  assign armed = (cnt == CNT_W'(ARM_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!armed) cnt <= cnt + CNT_W'(1);
  end

  assign evt = armed ? line_events(ref_lvl, lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lvl <= '0;
      dlt     <= '0;
    end else begin
      ref_lvl <= lvl;
      dlt     <= next_flags(dlt, clr, evt);
    end
  end
endmodule

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs
  import mcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       reg_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       gp1_o,
  output logic       gp2_o,
  output logic       loop_o,
  output logic       irq_o,
  output logic       irq_oe_o
);
  logic [7:0] ctl_q;
  lines_t     raw_lvl, sync_lvl, eff_lvl, ref_lvl, evt, dlt_q;
  logic       armed, ctl_we, stat_rd;

  assign ctl_we  = wr_en & ~reg_sel;
  assign stat_rd = rd_en & reg_sel;

  always_comb begin
    raw_lvl        = '0;
    raw_lvl[L_CTS] = cts_i;
    raw_lvl[L_DSR] = dsr_i;
    raw_lvl[L_RI]  = ri_i;
    raw_lvl[L_DCD] = dcd_i;
  end

  mcr_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (wdata),
    .ctl   (ctl_q)
  );

  mcr_sync #(.STAGES(SYNC_STAGES), .W(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_lvl),
    .q     (sync_lvl)
  );

  assign eff_lvl = ctl_q[B_LOOP] ? loop_lines(ctl_q) : sync_lvl;

  mcr_delta #(.STAGES(SYNC_STAGES)) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (stat_rd),
    .lvl     (eff_lvl),
    .ref_lvl (ref_lvl),
    .evt     (evt),
    .dlt     (dlt_q),
    .armed   (armed)
  );

  assign rdata    = reg_sel ? status_word(dlt_q, ref_lvl) : ctl_q;
  assign dtr_o    = ctl_q[B_DTR];
  assign rts_o    = ctl_q[B_RTS];
  assign gp1_o    = ctl_q[B_GP1];
  assign gp2_o    = ctl_q[B_GP2];
  assign loop_o   = ctl_q[B_LOOP];
  assign irq_o    = dlt_q[L_RI] | dlt_q[L_DCD];
  assign irq_oe_o = ctl_q[B_GP2];
endmodule

// File: rtl/mcr_chk.sv
module mcr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       reg_sel,
  input logic [7:0] wdata,
  input logic [7:0] ctl_q,
  input logic [3:0] dlt_q,
  input logic [3:0] eff_lvl,
  input logic [3:0] ref_lvl,
  input logic       armed
);
  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (ctl_q == {3'b000, $past(wdata[4:0])}));

  // R3
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> $stable(ctl_q));

  // R5
  cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (eff_lvl[0] != ref_lvl[0])) |=> dlt_q[0]);

  // R6
  ri_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ref_lvl[2] && eff_lvl[2] && !dlt_q[2]) |=> !dlt_q[2]);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && armed && (eff_lvl == ref_lvl)) |=> (dlt_q == 4'b0000));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && armed && (eff_lvl[3] != ref_lvl[3])) |=> dlt_q[3]);

  // R12
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (dlt_q == 4'b0000));
endmodule

bind modem_ctl_regs mcr_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .reg_sel (reg_sel),
  .wdata   (wdata),
  .ctl_q   (ctl_q),
  .dlt_q   (dlt_q),
  .eff_lvl (eff_lvl),
  .ref_lvl (ref_lvl),
  .armed   (armed)
);

// File: tb/modem_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module modem_ctl_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cts_i = 1'b0, dsr_i = 1'b0, ri_i = 1'b0, dcd_i = 1'b0;
  logic       dtr_o, rts_o, gp1_o, gp2_o, loop_o, irq_o, irq_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  modem_ctl_regs #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .dtr_o(dtr_o), .rts_o(rts_o), .gp1_o(gp1_o), .gp2_o(gp2_o),
    .loop_o(loop_o), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  // {control write, raw {dcd,ri,dsr,cts}, expected status word read after settling}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    20'h00151, 20'h00510, 20'h00154, 20'h00BFA, 20'hE0BF0, 20'h10B4B, 20'h1F0BB,
    20'h1B0F4, 20'h1205A, 20'h00041, 20'h08262, 20'h04402, 20'h10044, 20'h00040
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic set_raw(input logic [3:0] r);
    {dcd_i, ri_i, dsr_i, cts_i} = r;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d, input logic [3:0] r);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wdata = d; set_raw(r);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read without clearing
  task automatic peek(input logic sel, output logic [7:0] v);
    rd_en = 1'b0; reg_sel = sel;
    #1 v = rdata;
  endtask

  // strobed read (clears flags when sel = 1)
  task automatic read_reg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    // R12: levels held across reset release must not show up as changes
    set_raw(4'hF);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle(6);
    peek(1'b0, v);  check("R1 control after reset", v, 8'h00);
    check("R1 outputs after reset", {3'b0, loop_o, gp2_o, gp1_o, rts_o, dtr_o}, 8'h00);
    check("R1 irq and driver after reset", {6'b0, irq_o, irq_oe_o}, 8'h00);
    peek(1'b1, v);  check("R12 no flags from reset levels", v, 8'hB0);
    // drop all lines: three toggles and a trailing RI edge
    set_raw(4'h0);
    settle(5);
    check("R9 irq from ring/carrier flags", {7'b0, irq_o}, 8'h01);
    read_reg(1'b1, v); check("R5 R6 all lines dropped", v, 8'h4F);
    peek(1'b1, v);  check("R7 flags cleared by read", v, 8'h40);

    // R3: write aimed at the status register is ignored
    write_reg(1'b1, 8'hFF, 4'h0);
    settle(2);
    peek(1'b0, v);  check("R3 control untouched", v, 8'h00);
    peek(1'b1, v);  check("R3 status untouched", v, 8'h40);

    // table walk: R2 R4 R5 R6 R9 R10 R11 R13
    for (int i = 0; i < NV; i++) begin
      logic [7:0] c, e;
      c = VEC[i][19:12];
      e = VEC[i][7:0];
      write_reg(1'b0, c, VEC[i][11:8]);
      settle(6);
      peek(1'b0, v);
      check($sformatf("R2 readback vec%0d", i), v, c & 8'h1F);
      check($sformatf("R2 pins vec%0d", i),
            {3'b0, loop_o, gp2_o, gp1_o, rts_o, dtr_o}, c & 8'h1F);
      check($sformatf("R10 driver enable vec%0d", i), {7'b0, irq_oe_o}, {7'b0, c[3]});
      check($sformatf("R9 irq vec%0d", i), {7'b0, irq_o}, {7'b0, e[2] | e[3]});
      read_reg(1'b1, v);
      check($sformatf("R4 R11 R13 status vec%0d", i), v, e);
    end

    // R7: reading the control register clears nothing
    write_reg(1'b0, 8'h00, 4'h1);
    settle(6);
    read_reg(1'b0, v); check("R7 control read value", v, 8'h00);
    peek(1'b1, v);     check("R7 flag kept after control read", v, 8'h51);
    read_reg(1'b1, v); check("R7 status read returns flag", v, 8'h51);
    peek(1'b1, v);     check("R7 flag cleared", v, 8'h50);

    // R8: change lands on the same edge as a clearing read
    @(negedge clk);
    set_raw(4'h0);
    settle(2);
    rd_en = 1'b1; reg_sel = 1'b1;
    #1 v = rdata;
    check("R8 read returns pre-update value", v, 8'h50);
    @(negedge clk);
    rd_en = 1'b0;
    peek(1'b1, v);     check("R8 set wins over clear", v, 8'h41);
    read_reg(1'b1, v); check("R8 flag then readable", v, 8'h41);

    summary();
  end
endmodule